// File: doc/BRIEF.md
# Microprogram Sequencer

This block is the control unit of a multicycle processor, built as a sequencer. A 4-bit micro-program counter (micro-PC) selects one word of a control store. The store has one word for each state. Each word holds 17 bits of datapath control and a 2-bit field that says how the next micro-PC is formed. The field can choose a return to state 0, a lookup in one of two tables indexed by the 6-bit opcode, or the current state plus one.

The datapath control bits of the current state drive the `dp_ctrl` output. The micro-PC is also visible on `upc_dbg`, so the sequence for each instruction class can be watched from outside.

The reset input is asserted asynchronously. Its release passes through a small synchronizer, so the micro-PC starts stepping only on the third rising clock edge after `rst_n` goes high.

Top module: `useq_sequencer`

## Requirements
- R1: While `rst_n` is low the micro-PC is 0, and this takes effect without waiting for a clock edge. After `rst_n` rises, the micro-PC stays at 0 for two rising edges and leaves 0 on the third.
- R2: The select code 11 loads the current micro-PC plus one on the next rising edge. States 0, 3, 6 and 10 carry this code.
- R3: The select code 01 is used only by state 1. It loads the first dispatch table entry for the opcode: 000000 goes to 6, 000010 to 9, 000100 to 8, 001011 to 10, and both 100011 and 101011 go to 2.
- R4: The select code 10 is used only by state 2. It loads the second dispatch table entry for the opcode: 100011 goes to 3 and 101011 goes to 5.
- R5: The select code 00 loads 0. States 4, 5, 7, 8, 9 and 11 carry this code, and so do all unused states 12 to 15.
- R6: An opcode that has no entry in the table being consulted sends the micro-PC to 0.
- R7: Opcode 100011 (load) steps through 0, 1, 2, 3, 4 and back to 0.
- R8: Opcode 101011 (store) steps through 0, 1, 2, 5 and back to 0.
- R9: Register-register operations step through 0, 1, 6, 7. OR-immediate steps through 0, 1, 10, 11. Branch-equal steps through 0, 1, 8. Jump steps through 0, 1, 9. Each then returns to 0.
- R10: `dp_ctrl` is the control word of the current state. Bit 16 is the PC write and is 1 only in states 0 and 9. Bit 8 is the instruction register write and is 1 only in state 0. Bit 9 is the memory write and is 1 only in state 5. Bit 6 is the register file write and is 1 only in states 4, 7 and 11.
- R11: The opcode is sampled only at the edges that leave state 1 or state 2. A change in any other state does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction being decoded |
| dp_ctrl | output | 17 | Datapath control vector of the current state |
| upc_dbg | output | 4 | Current micro-PC value |

## Verification
The bench builds the block with its defaults: a 4-bit micro-PC, a 6-bit opcode and a two-stage reset synchronizer. With these values every reachable state from 0 to 11 is visited, and every dispatch entry is taken, along with opcodes that have no entry. Directed cases change the opcode between the two dispatch points, which reaches a miss in the second table. They also change the opcode in a sequential state, and they pull reset in the middle of an instruction to show the synchronized restart.

// File: rtl/useq_pkg.sv
package useq_pkg;

  localparam int UPC_W = 4;
  localparam int OP_W  = 6;
  localparam int SEL_W = 2;
  localparam int DEPTH = 1 << UPC_W;

  typedef enum logic [SEL_W-1:0] {
    SEL_ZERO = 2'b00,
    SEL_MAP1 = 2'b01,
    SEL_MAP2 = 2'b10,
    SEL_NEXT = 2'b11
  } sel_e;

  typedef struct packed {
    logic       pc_we;
    logic       pc_cond_we;
    logic       pc_src;
    logic       tgt_we;
    logic       alu_a_sel;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_we;
    logic       ir_we;
    logic       dst_sel;
    logic       reg_we;
    logic       wb_sel;
    logic       ext_sign;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
  } dp_ctrl_t;

  localparam int DP_W = $bits(dp_ctrl_t);
  localparam int CW_W = DP_W + SEL_W;

  // opcode values that index the dispatch tables
  localparam logic [OP_W-1:0] OPC_RR   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JMP  = 6'b000010;
  localparam logic [OP_W-1:0] OPC_BEQ  = 6'b000100;
  localparam logic [OP_W-1:0] OPC_ORI  = 6'b001011;
  localparam logic [OP_W-1:0] OPC_LOAD = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STOR = 6'b101011;

  // state numbers
  localparam int ST_FETCH   = 0;
  localparam int ST_DECODE  = 1;
  localparam int ST_ADDR    = 2;
  localparam int ST_LD_MEM  = 3;
  localparam int ST_LD_WB   = 4;
  localparam int ST_ST_MEM  = 5;
  localparam int ST_RR_EXE  = 6;
  localparam int ST_RR_WB   = 7;
  localparam int ST_BRANCH  = 8;
  localparam int ST_JUMP    = 9;
  localparam int ST_ORI_EXE = 10;
  localparam int ST_ORI_WB  = 11;

  // ALU operation and B-operand encodings
  localparam logic [1:0] ALU_ADD  = 2'b00;
  localparam logic [1:0] ALU_SUB  = 2'b01;
  localparam logic [1:0] ALU_FUNC = 2'b10;
  localparam logic [1:0] ALU_OR   = 2'b11;
  localparam logic [1:0] B_REG    = 2'b00;
  localparam logic [1:0] B_FOUR   = 2'b01;
  localparam logic [1:0] B_BRANCH = 2'b10;
  localparam logic [1:0] B_IMM    = 2'b11;

endpackage

// File: rtl/useq_rst_sync.sv
module useq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/useq_ctrl_store.sv
module useq_ctrl_store
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  logic [AW-1:0] upc,
  output dp_ctrl_t      dp,
  output sel_e          sel
);
  always_comb begin
    dp  = '0;
    sel = SEL_ZERO;
    case (int'(upc))
      ST_FETCH: begin
        dp.pc_we = 1'b1; dp.ir_we = 1'b1; dp.mem_rd = 1'b1;
        dp.alu_b_sel = B_FOUR; dp.alu_op = ALU_ADD;
        sel = SEL_NEXT;
      end
      ST_DECODE: begin
        dp.tgt_we = 1'b1; dp.ext_sign = 1'b1;
        dp.alu_b_sel = B_BRANCH; dp.alu_op = ALU_ADD;
        sel = SEL_MAP1;
      end
      ST_ADDR: begin
        dp.alu_a_sel = 1'b1; dp.ext_sign = 1'b1;
        dp.alu_b_sel = B_IMM; dp.alu_op = ALU_ADD;
        sel = SEL_MAP2;
      end
      ST_LD_MEM: begin
        dp.alu_a_sel = 1'b1; dp.ext_sign = 1'b1; dp.addr_sel = 1'b1;
        dp.mem_rd = 1'b1; dp.alu_b_sel = B_IMM; dp.alu_op = ALU_ADD;
        sel = SEL_NEXT;
      end
      ST_LD_WB: begin
        dp.alu_a_sel = 1'b1; dp.ext_sign = 1'b1; dp.addr_sel = 1'b1;
        dp.mem_rd = 1'b1; dp.reg_we = 1'b1; dp.wb_sel = 1'b1;
        dp.alu_b_sel = B_IMM; dp.alu_op = ALU_ADD;
        sel = SEL_ZERO;
      end
      ST_ST_MEM: begin
        dp.alu_a_sel = 1'b1; dp.ext_sign = 1'b1; dp.addr_sel = 1'b1;
        dp.mem_we = 1'b1; dp.alu_b_sel = B_IMM; dp.alu_op = ALU_ADD;
        sel = SEL_ZERO;
      end
      ST_RR_EXE: begin
        dp.alu_a_sel = 1'b1; dp.dst_sel = 1'b1;
        dp.alu_b_sel = B_REG; dp.alu_op = ALU_FUNC;
        sel = SEL_NEXT;
      end
      ST_RR_WB: begin
        dp.alu_a_sel = 1'b1; dp.dst_sel = 1'b1; dp.reg_we = 1'b1;
        dp.alu_b_sel = B_REG; dp.alu_op = ALU_FUNC;
        sel = SEL_ZERO;
      end
      ST_BRANCH: begin
        dp.alu_a_sel = 1'b1; dp.pc_cond_we = 1'b1; dp.pc_src = 1'b1;
        dp.alu_b_sel = B_REG; dp.alu_op = ALU_SUB;
        sel = SEL_ZERO;
      end
      ST_JUMP: begin
        dp.pc_we = 1'b1; dp.pc_src = 1'b1;
        sel = SEL_ZERO;
      end
      ST_ORI_EXE: begin
        dp.alu_a_sel = 1'b1; dp.alu_b_sel = B_IMM; dp.alu_op = ALU_OR;
        sel = SEL_NEXT;
      end
      ST_ORI_WB: begin
        dp.alu_a_sel = 1'b1; dp.reg_we = 1'b1;
        dp.alu_b_sel = B_IMM; dp.alu_op = ALU_OR;
        sel = SEL_ZERO;
      end
      default: begin
        dp  = '0;
        sel = SEL_ZERO;
      end
    endcase
  end

  // a memory write must never coincide with a register write
  always_comb begin
    AST_WE_EXCLUSIVE: assert (!(dp.mem_we && dp.reg_we)); // R10
  end
endmodule

// File: rtl/useq_dispatch.sv
module useq_dispatch
  import useq_pkg::*;
#(
  parameter int TBL = 1,
  parameter int AW  = UPC_W,
  parameter int OW  = OP_W
) (
  input  logic [OW-1:0] opcode,
  output logic [AW-1:0] target
);
  generate
    if (TBL == 1) begin : g_first
      always_comb begin
        case (opcode)
          OPC_RR:   target = AW'(ST_RR_EXE);
          OPC_JMP:  target = AW'(ST_JUMP);
          OPC_BEQ:  target = AW'(ST_BRANCH);
          OPC_ORI:  target = AW'(ST_ORI_EXE);
          OPC_LOAD: target = AW'(ST_ADDR);
          OPC_STOR: target = AW'(ST_ADDR);
          default:  target = '0;
        endcase
      end
    end else begin : g_second
      always_comb begin
        case (opcode)
          OPC_LOAD: target = AW'(ST_LD_MEM);
          OPC_STOR: target = AW'(ST_ST_MEM);
          default:  target = '0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr
  import useq_pkg::*;
#(
  parameter int AW = UPC_W
) (
  input  sel_e          sel,
  input  logic [AW-1:0] upc,
  input  logic [AW-1:0] map1,
  input  logic [AW-1:0] map2,
  output logic [AW-1:0] upc_nxt
);
  always_comb begin
    case (sel)
      SEL_ZERO: upc_nxt = '0;
      SEL_MAP1: upc_nxt = map1;
      SEL_MAP2: upc_nxt = map2;
      SEL_NEXT: upc_nxt = upc + AW'(1);
      default:  upc_nxt = '0;
    endcase
  end
endmodule

// File: rtl/useq_sequencer.sv
module useq_sequencer
  import useq_pkg::*;
#(
  parameter int AW          = UPC_W,
  parameter int OW          = OP_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [OW-1:0]   opcode,
  output logic [DP_W-1:0] dp_ctrl,
  output logic [AW-1:0]   upc_dbg
);
  logic          rst_sync_n;
  logic [AW-1:0] upc_q;
  logic [AW-1:0] upc_nxt;
  logic [AW-1:0] map1;
  logic [AW-1:0] map2;
  dp_ctrl_t      dp;
  sel_e          sel;

  useq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  useq_ctrl_store #(.AW(AW)) u_store (
    .upc(upc_q), .dp(dp), .sel(sel)
  );

  useq_dispatch #(.TBL(1), .AW(AW), .OW(OW)) u_map1 (
    .opcode(opcode), .target(map1)
  );

  useq_dispatch #(.TBL(2), .AW(AW), .OW(OW)) u_map2 (
    .opcode(opcode), .target(map2)
  );

  useq_next_addr #(.AW(AW)) u_next (
    .sel(sel), .upc(upc_q), .map1(map1), .map2(map2), .upc_nxt(upc_nxt)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) upc_q <= '0;
    else             upc_q <= upc_nxt;
  end

  assign dp_ctrl = dp;
  assign upc_dbg = upc_q;

  AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_ZERO) |=> (upc_q == '0)); // R5
  AST_NEXT_SEL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_NEXT) |=> (upc_q == $past(upc_q) + AW'(1))); // R2
  AST_MAP1_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_MAP1) |=> (upc_q == AW'(0) || upc_q == AW'(2) || upc_q == AW'(6) ||
                           upc_q == AW'(8) || upc_q == AW'(9) || upc_q == AW'(10))); // R3
  AST_MAP2_LEGAL: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_MAP2) |=> (upc_q == AW'(0) || upc_q == AW'(3) || upc_q == AW'(5))); // R4
  AST_MEM_WE_STATE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    dp.mem_we |-> (upc_q == AW'(5))); // R10
  AST_MAP1_FROM_DECODE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sel == SEL_MAP1) |-> (upc_q == AW'(1))); // R3
endmodule

// File: tb/tb_useq_sequencer.sv
`timescale 1ns/1ps
module tb_useq_sequencer;
  logic        clk;
  logic        rst_n;
  logic [5:0]  opcode;
  logic [16:0] dp_ctrl;
  logic [3:0]  upc_dbg;
  int tests;
  int fails;
  bit done;

  useq_sequencer dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode),
    .dp_ctrl(dp_ctrl), .upc_dbg(upc_dbg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  localparam int NV = 8;
  localparam logic [5:0]  V_OP  [NV] = '{6'b100011, 6'b101011, 6'b000000, 6'b001011,
                                          6'b000100, 6'b000010, 6'b111111, 6'b100000};
  localparam int          V_LEN [NV] = '{5, 4, 4, 4, 3, 3, 2, 2};
  localparam logic [23:0] V_SEQ [NV] = '{24'h012340, 24'h012500, 24'h016700, 24'h01AB00,
                                          24'h018000, 24'h019000, 24'h010000, 24'h010000};
  localparam string       V_TAG [NV] = '{"R7 R2 R3 R4", "R8 R3 R4 R5", "R9 R3", "R9 R2",
                                          "R9 R5", "R9 R3", "R6", "R6"};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R10: expected control bits from the state number
  task automatic chk_ctrl(input int st);
    logic [3:0] exp_bits;
    logic [3:0] act_bits;
    exp_bits = {(st == 0 || st == 9), (st == 0), (st == 5), (st == 4 || st == 7 || st == 11)};
    act_bits = {dp_ctrl[16], dp_ctrl[8], dp_ctrl[9], dp_ctrl[6]};
    chk(act_bits == exp_bits, "R10", int'(act_bits), int'(exp_bits));
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    tests = 0; fails = 0; done = 0;
    rst_n = 1'b0;
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    chk(upc_dbg == 4'd0, "R1 reset", upc_dbg, 0);
    release_reset();
    chk(upc_dbg == 4'd0, "R1 hold", upc_dbg, 0);

    // table walk: every vector starts and ends at state 0
    for (int i = 0; i < NV; i++) begin
      opcode = V_OP[i];
      for (int k = 0; k < V_LEN[i]; k++) begin
        chk(upc_dbg == V_SEQ[i][23-4*k -: 4], V_TAG[i], upc_dbg, V_SEQ[i][23-4*k -: 4]);
        chk_ctrl(int'(upc_dbg));
        @(negedge clk);
      end
    end
    chk(upc_dbg == 4'd0, "R5 final", upc_dbg, 0);

    // R6: second-table miss, opcode altered after leaving state 1
    opcode = 6'b100011;
    @(negedge clk);
    @(negedge clk);
    chk(upc_dbg == 4'd2, "R6 setup", upc_dbg, 2);
    opcode = 6'b000100;
    @(negedge clk);
    chk(upc_dbg == 4'd0, "R6 map2 miss", upc_dbg, 0);

    // R11: opcode change in a sequential state is ignored
    opcode = 6'b100011;
    repeat (3) @(negedge clk);
    chk(upc_dbg == 4'd3, "R11 setup", upc_dbg, 3);
    opcode = 6'b000000;
    @(negedge clk);
    chk(upc_dbg == 4'd4, "R11", upc_dbg, 4);
    @(negedge clk);
    chk(upc_dbg == 4'd0, "R11 R5", upc_dbg, 0);

    // R1: reset in mid instruction clears at once, restart after sync
    opcode = 6'b101011;
    repeat (2) @(negedge clk);
    chk(upc_dbg == 4'd2, "R1 setup", upc_dbg, 2);
    rst_n = 1'b0;
    #1;
    chk(upc_dbg == 4'd0, "R1 async", upc_dbg, 0);
    repeat (2) @(negedge clk);
    chk(upc_dbg == 4'd0, "R1 held", upc_dbg, 0);
    release_reset();
    chk(upc_dbg == 4'd0, "R1 post", upc_dbg, 0);
    @(negedge clk);
    chk(upc_dbg == 4'd1, "R1 restart", upc_dbg, 1);
    @(negedge clk);
    chk(upc_dbg == 4'd2, "R3", upc_dbg, 2);
    @(negedge clk);
    chk(upc_dbg == 4'd5, "R4 R8", upc_dbg, 5);
    chk_ctrl(int'(upc_dbg));

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule